// File: doc/BRIEF.md
# SPI Burst Register Access Slave

This block is an SPI slave (clock idle low, data captured on the rising edge, launched on the falling edge) that lets a host read and write a bank of 16-bit registers held outside the block. A frame runs while chip select is low. It opens with one command byte, followed by any number of 16-bit data words. Each data word acts on the current register address. After every complete word the address pointer moves on, so a long frame becomes a burst over several registers.

The pointer normally steps linearly. With the contextual mode input set, two kinds of burst instead visit only the ports of a matching type, in ascending order, and wrap back to the lowest one:
- a write burst that starts in the output-port data bank;
- a read burst that starts in the input-port data bank.

A fixed access map decides which addresses take writes, which are read-only, and which are unused. Writes to unused or read-only addresses are dropped, and unused addresses read as zero.

The serial pins are sampled by the system clock through synchronizers, so each SCLK level must last at least 4 system clock cycles. The register port has no back-pressure, which is why it is a plain strobe port and not valid/ready. The bank must take a write in the single cycle `reg_wr` is high. It must also present `reg_rdata` for `reg_addr` combinationally, within one cycle of the address changing. Port p's 2-bit type occupies `port_type[2p+1:2p]`.

Top module: `spi_burst_regs`

## Requirements
- R1: The first 8 bits of a frame, taken MSB first on rising SCLK edges, form the command byte. Bits 7:1 are the start address and bit 0 is the direction: 1 means read, 0 means write.
- R2: On a read, each 16-bit word of the addressed register appears on `dout` MSB first. The first bit is launched after the falling edge that ends the command byte, ready for the next rising edge.
- R3: A write word is taken MSB first. Exactly one one-cycle `reg_wr` pulse carries the word, and it comes only after its 16th bit has been received.
- R4: If chip select rises before a word is complete, that word is never written. Words completed earlier in the same frame stay written, and the next frame decodes normally.
- R5: In linear mode the address rises by one after every word.
- R6: In linear mode the pointer stays at 0x7F for any further words once it gets there.
- R7: The access map has four kinds of address:
  - writable: 0x10–0x1F, 0x20–0x2B (port config), 0x60–0x6B (output-port data) and 0x70–0x7F;
  - read-only: 0x00 and 0x40–0x4B (input-port data);
  - unused: every other address.
  Writes to an unused address make no strobe, and reads from one return zero.
- R8: Writes to a read-only address make no strobe.
- R9: This requirement applies when `ctx_mode`=1 and a write burst starts in 0x60–0x6B. Each next address is the data register of the next higher port whose type is 2'b01. After the highest such port it wraps to the lowest one. If no port has that type, the address holds.
- R10: This requirement applies when `ctx_mode`=1 and a read burst starts in 0x40–0x4B. It steps through the ports of type 2'b10 in the same way as R9, including the wrap and the hold when there are none.
- R11: With `ctx_mode`=1, every other burst steps linearly. This includes writes elsewhere, reads of 0x60–0x6B and writes into 0x40–0x4B.
- R12: `dout` is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| ctx_mode | input | 1 | 0 linear stepping, 1 contextual stepping |
| port_type | input | 2*NP | 2-bit type per port |
| reg_addr | output | 7 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read data for reg_addr |

## Verification
Single-word frames set apart the command decode, the MSB-first order and the read data path. Linear bursts that cross unused or read-only addresses, or that run into 0x7F, set apart incrementing, holding and write suppression. Frames cut off after 0, 9 and 20 data bits show that only whole words are written. The contextual mode is swept over every start port under four type layouts. These are sparse, single-port, all-output and scattered layouts. Each sweep runs both the output-write and input-read walks, which covers the wrap, the hold when no port has the type, and starts on ports of the wrong type.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int NPORTS = 12;

  localparam logic [AW-1:0] ADDR_MAX  = 7'h7F;
  localparam logic [AW-1:0] CFG_BASE  = 7'h20;
  localparam logic [AW-1:0] ADC_BASE  = 7'h40;
  localparam logic [AW-1:0] DAC_BASE  = 7'h60;

  localparam logic [1:0] PT_DAC = 2'b01;
  localparam logic [1:0] PT_ADC = 2'b10;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO} acc_e;

  function automatic logic in_bank(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a >= base) && (a < base + AW'(NPORTS));
  endfunction

  function automatic acc_e acc_class(input logic [AW-1:0] a);
    if (a == '0) return ACC_RO;
    if (a[6:4] == 3'h1 || a[6:4] == 3'h7) return ACC_RW;
    if (in_bank(a, CFG_BASE) || in_bank(a, DAC_BASE)) return ACC_RW;
    if (in_bank(a, ADC_BASE)) return ACC_RO;
    return ACC_NONE;
  endfunction
endpackage

// File: rtl/spi_burst_sync.sv
module spi_burst_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_burst_step.sv
module spi_burst_step
  import spi_burst_pkg::*;
#(
  parameter int NP = NPORTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cur,
  input  logic            ctx_en,
  input  logic [AW-1:0]   base,
  input  logic [1:0]      want,
  input  logic [2*NP-1:0] ptype,
  output logic [AW-1:0]   nxt
);
  logic [AW-1:0] off, first_a, after_a, nidx;
  logic          found_any, found_aft;
  logic [1:0]    nsel;

  assign off = cur - base;

  always_comb begin
    found_any = 1'b0;
    found_aft = 1'b0;
    first_a   = cur;
    after_a   = cur;
    for (int p = NP-1; p >= 0; p--) begin
      if (ptype[2*p +: 2] == want) begin
        found_any = 1'b1;
        first_a   = base + AW'(p);
        if (AW'(p) > off) begin
          found_aft = 1'b1;
          after_a   = base + AW'(p);
        end
      end
    end
  end

  always_comb begin
    if (ctx_en) nxt = found_aft ? after_a : first_a;
    else        nxt = (cur == ADDR_MAX) ? cur : cur + 1'b1;
  end

  assign nidx = nxt - base;
  assign nsel = 2'(ptype >> (2 * int'(nidx)));

  // R9 R10
  ctx_target_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_en && found_any) |-> (nidx < AW'(NP)) && (nsel == want));
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
  import spi_burst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NP = NPORTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            din,
  output logic            dout,
  input  logic            ctx_mode,
  input  logic [2*NP-1:0] port_type,
  output logic [AW-1:0]   reg_addr,
  output logic [DW-1:0]   reg_wdata,
  output logic            reg_wr,
  input  logic [DW-1:0]   reg_rdata
);
  localparam int CW = $clog2(DW);

  logic [2:0] s_q;
  logic       cs_act, sclk_s, din_s, sclk_d, sclk_rise, sclk_fall;

  spi_burst_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(s_q)
  );

  assign cs_act = ~s_q[2];
  assign sclk_s = s_q[1];
  assign din_s  = s_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = cs_act & sclk_s & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_s & sclk_d;

  logic          in_data, rnw_q, ctx_q, adv_q, wr_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_sh, tx_sh, wdata_q;
  logic [AW-1:0] ptr, step_nxt, ctx_base;
  logic [DW-1:0] rx_next, rd_val;
  logic [1:0]    want;

  assign rx_next  = {rx_sh[DW-2:0], din_s};
  assign ctx_base = rnw_q ? ADC_BASE : DAC_BASE;
  assign want     = rnw_q ? PT_ADC : PT_DAC;
  assign rd_val   = (acc_class(ptr) == ACC_NONE) ? '0 : reg_rdata;

  spi_burst_step #(.NP(NP)) u_step (
    .clk(clk), .rst_n(rst_n), .cur(ptr), .ctx_en(ctx_q), .base(ctx_base),
    .want(want), .ptype(port_type), .nxt(step_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= 1'b0;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rnw_q   <= 1'b0;
      ctx_q   <= 1'b0;
      ptr     <= '0;
      adv_q   <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (adv_q) begin
        ptr   <= step_nxt;
        adv_q <= 1'b0;
      end
      if (!cs_act) begin
        in_data <= 1'b0;
        cnt     <= '0;
        tx_sh   <= '0;
      end else begin
        if (sclk_rise) begin
          rx_sh <= rx_next;
          if (!in_data) begin
            if (cnt == CW'(7)) begin
              ptr     <= rx_next[7:1];
              rnw_q   <= rx_next[0];
              ctx_q   <= ctx_mode & (rx_next[0] ? in_bank(rx_next[7:1], ADC_BASE)
                                                : in_bank(rx_next[7:1], DAC_BASE));
              in_data <= 1'b1;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              adv_q   <= 1'b1;
              wr_q    <= ~rnw_q & (acc_class(ptr) == ACC_RW);
              wdata_q <= rx_next;
            end
          end
        end
        if (sclk_fall && in_data) begin
          if (cnt == '0) tx_sh <= rnw_q ? rd_val : '0;
          else           tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign dout      = cs_act & tx_sh[DW-1];
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;

  // R3
  wr_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(sclk_rise));
  // R8
  wr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (acc_class(reg_addr) == ACC_RW));
  // R5
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_q && !ctx_q && ptr != ADDR_MAX) |=> (reg_addr == $past(reg_addr) + 7'd1));
  // R6
  lin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_q && !ctx_q && ptr == ADDR_MAX) |=> (reg_addr == ADDR_MAX));
endmodule

// File: tb/spi_burst_regs_tb.sv
module spi_burst_regs_tb;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, ctx_mode = 1'b0;
  logic [23:0] port_type = '0;
  logic dout, reg_wr;
  logic [6:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  logic [15:0] bank [128];
  logic [15:0] exp_bank [128];
  logic [15:0] tx [8];
  logic [15:0] rx [8];
  int wr_cnt = 0;
  int exp_wr = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spi_burst_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .ctx_mode(ctx_mode), .port_type(port_type), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin
      bank[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0123) ^ 16'h5A5A);
  endfunction

  // 0 unused, 1 writable, 2 read-only (R7 map)
  function automatic int acc(input int a);
    if (a == 0) return 2;
    if ((a >= 16 && a < 32) || a >= 112) return 1;
    if ((a >= 32 && a < 44) || (a >= 96 && a < 108)) return 1;
    if (a >= 64 && a < 76) return 2;
    return 0;
  endfunction

  function automatic int nxt_addr(input int cur, input bit ctx, input int base, input int want);
    if (!ctx) return (cur == 127) ? cur : cur + 1;
    for (int p = 0; p < 12; p++)
      if (int'(port_type[2*p +: 2]) == want && p > cur - base) return base + p;
    for (int p = 0; p < 12; p++)
      if (int'(port_type[2*p +: 2]) == want) return base + p;
    return cur;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    int mis = 0;
    for (int a = 0; a < 128; a++)
      if (bank[a] !== exp_bank[a] && mis == 0) mis = a;
    check(req, "bank", int'(bank[mis]), int'(exp_bank[mis]));
  endtask

  task automatic send_bit(input logic b, output logic got);
    din = b;
    repeat (H) @(negedge clk);
    got = dout;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  // one frame on the pins, then the model, then the checks
  task automatic do_frame(input int a, input bit rnw, input int nw, input int abort_bits,
                          input string req);
    logic [7:0] cmd;
    logic g;
    int nbits, done_w, cur, base, want;
    bit ctx;
    logic [15:0] exp_rx [8];
    cmd = {7'(a), rnw};
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 7; i >= 0; i--) send_bit(cmd[i], g);
    nbits = 0;
    for (int w = 0; w < nw; w++) begin
      for (int b = 15; b >= 0; b--) begin
        if (abort_bits >= 0 && nbits == abort_bits) break;
        send_bit(tx[w][b], g);
        rx[w][b] = g;
        nbits++;
      end
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*H) @(negedge clk);
    // model
    done_w = (abort_bits >= 0) ? abort_bits / 16 : nw;
    base = rnw ? 64 : 96;
    want = rnw ? 2 : 1;
    ctx = ctx_mode && (a >= base && a < base + 12);
    cur = a;
    for (int w = 0; w < done_w; w++) begin
      exp_rx[w] = (acc(cur) == 0) ? 16'h0 : exp_bank[cur];
      if (!rnw && acc(cur) == 1) begin
        exp_bank[cur] = tx[w];
        exp_wr++;
      end
      cur = nxt_addr(cur, ctx, base, want);
    end
    if (rnw)
      for (int w = 0; w < done_w; w++) check(req, "rdata", int'(rx[w]), int'(exp_rx[w]));
    check(req, "writes", wr_cnt, exp_wr);
    check_bank(req);
    // R12
    check("R12", "dout idle", int'(dout), 0);
  endtask

  task automatic fill_tx(input int seed);
    for (int w = 0; w < 8; w++) tx[w] = 16'(seed + w * 16'h1357);
  endtask

  task automatic set_types(input logic [11:0] dm, input logic [11:0] am);
    for (int p = 0; p < 12; p++)
      port_type[2*p +: 2] = dm[p] ? 2'b01 : (am[p] ? 2'b10 : 2'b11);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] dm [4];
    dm[0] = 12'h892; dm[1] = 12'h001; dm[2] = 12'hFFF; dm[3] = 12'h428;
    for (int a = 0; a < 128; a++) begin
      bank[a] = pat(a);
      exp_bank[a] = pat(a);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", "reset dout", int'(dout), 0);
    check("R3", "reset wr", int'(reg_wr), 0);

    // R1 R3 single write, then read back (R2) and read of read-only id
    tx[0] = 16'hC3A5;
    do_frame(7'h12, 1'b0, 1, -1, "R3");
    do_frame(7'h12, 1'b1, 1, -1, "R2");
    do_frame(7'h00, 1'b1, 1, -1, "R1");
    // R5 linear bursts
    fill_tx(16'h1000);
    do_frame(7'h13, 1'b0, 5, -1, "R5");
    do_frame(7'h20, 1'b1, 4, -1, "R5");
    // R6 hold at top
    fill_tx(16'h7E00);
    do_frame(7'h7E, 1'b0, 4, -1, "R6");
    do_frame(7'h7E, 1'b1, 4, -1, "R6");
    // R7 unused addresses
    fill_tx(16'h3030);
    do_frame(7'h30, 1'b0, 1, -1, "R7");
    do_frame(7'h30, 1'b1, 1, -1, "R7");
    do_frame(7'h2A, 1'b0, 4, -1, "R7");
    do_frame(7'h2A, 1'b1, 4, -1, "R7");
    // R8 read-only addresses
    fill_tx(16'h4141);
    do_frame(7'h41, 1'b0, 2, -1, "R8");
    do_frame(7'h00, 1'b0, 1, -1, "R8");
    // R4 aborted words
    fill_tx(16'hAB00);
    do_frame(7'h15, 1'b0, 1, 9, "R4");
    do_frame(7'h15, 1'b0, 1, -1, "R4");
    do_frame(7'h16, 1'b0, 2, 20, "R4");
    do_frame(7'h18, 1'b0, 1, 0, "R4");
    // R11 contextual mode, bursts that stay linear
    ctx_mode = 1'b1;
    set_types(12'hFFF, 12'h000);
    fill_tx(16'h2200);
    do_frame(7'h20, 1'b0, 3, -1, "R11");
    do_frame(7'h60, 1'b1, 3, -1, "R11");
    do_frame(7'h44, 1'b0, 2, -1, "R11");
    ctx_mode = 1'b0;
    do_frame(7'h61, 1'b0, 3, -1, "R11");
    // R9 R10 contextual sweeps over layouts and start ports
    ctx_mode = 1'b1;
    for (int m = 0; m < 4; m++) begin
      set_types(dm[m], ~dm[m]);
      for (int s = 0; s < 12; s++) begin
        fill_tx(16'h8000 + m * 256 + s * 16);
        do_frame(96 + s, 1'b0, 5, -1, "R9");
        do_frame(64 + s, 1'b1, 5, -1, "R10");
      end
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule